// File: doc/BRIEF.md
# Shift, Extend and Byte-Extract Unit

This unit is the bit-manipulation datapath of a small 32-bit RISC core. It takes one general register operand and returns a rewritten version of it. The available rewrites are arithmetic and logical shifts, a left rotate, bit reversal, single-bit shifts that report the lost bit as a new carry flag, sign and zero extension of the low byte or halfword, and extraction of any one of the four bytes. It is purely combinational, so a result is ready in the same cycle as its operands.

The surrounding core supplies a five-bit operation code, the operand, a six-bit shift amount and the current carry flag. It takes back the result, a new carry value with its write-enable, and a flag telling the register writer that the destination must be general register 1. Decoding instructions and reading or writing the register file are left to the core.

Top module: `bitedit_unit`

## Requirements
- R1: Operation codes on `op_sel` are: 0 arithmetic right by register, 1 arithmetic right by immediate, 2 arithmetic right one bit to carry, 3 left by register, 4 left by immediate, 5 left one bit to carry, 6 logical right by register, 7 logical right by immediate, 8 logical right one bit to carry, 9 rotate left by immediate, 10 bit reverse, 11 extended right shift through carry, 12 sign-extend byte, 13 sign-extend halfword, 14 zero-extend byte, 15 zero-extend halfword, 16 to 19 extract byte 0 to 3. Codes 20 to 31 give a zero result, no carry write and no register-1 destination.
- R2: Arithmetic right shifts (codes 0, 1) fill vacated bits with operand bit 31. The register form uses all six bits of `shamt`, and amounts from 32 to 63 give 32 copies of bit 31; the immediate form uses `shamt[4:0]` only.
- R3: Logical left and right shifts (codes 3, 4, 6, 7) fill with zeros. The register forms give zero for amounts from 32 to 63; the immediate forms use `shamt[4:0]` only.
- R4: The one-bit shifts (codes 2, 5, 8) shift by exactly one regardless of `shamt`. Codes 2 and 8 put operand bit 0 into the carry; code 5 puts operand bit 31 into the carry.
- R5: Rotate (code 9) moves every bit circularly left by `shamt[4:0]` positions; an amount of 0 returns the operand.
- R6: Bit reverse (code 10) places operand bit i in result bit 31-i for every i.
- R7: The extended right shift (code 11) shifts right by one, puts the incoming carry in result bit 31 and operand bit 0 in the new carry.
- R8: Sign extension (codes 12, 13) copies bit 7, or bit 15, into every higher bit and keeps the bits below.
- R9: Zero extension (codes 14, 15) keeps bits 7..0, or 15..0, and clears every bit above.
- R10: Extract byte n (codes 16+n) returns operand bits 8n+7..8n in result bits 7..0 with zeros above.
- R11: `carry_we` is 1 for codes 2, 5, 8 and 11 only; whenever it is 0, `carry_out` equals `carry_in`.
- R12: `dest_r1` is 1 for codes 16 to 19 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code, encodings in R1 |
| opnd | input | 32 | Register operand to be rewritten |
| shamt | input | 6 | Shift or rotate amount (register value low bits or immediate field) |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Rewritten operand |
| carry_out | output | 1 | New carry flag value |
| carry_we | output | 1 | Carry flag write-enable |
| dest_r1 | output | 1 | Destination forced to general register 1 |

## Verification
The unit holds no state, so a fault in the decode or in one barrel stage shows at the result port in the same evaluation as the offending operation code and amount; nothing is hidden for later cycles. A stuck stage-select shows only for amounts with that bit set, and a wrong fill or wrap shows only for operands whose vacated positions differ from the fill, which is why the sweep covers every amount from 0 to 63 against operands of all-ones, all-zeros, single-bit and pseudo-random patterns with both carry values. Carry and destination flags are compared on every vector, so a write-enable leaking onto a non-carry code is seen immediately as an altered carry.

// File: rtl/bitedit_pkg.sv
// Shared definitions for the shift, extend and byte-extract unit.
// Assumes a 32-bit datapath with four byte lanes; the operation codes
// below are part of the interface to instruction decode.
package bitedit_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ASR_R  = 5'd0,
        OP_ASR_I  = 5'd1,
        OP_ASR_1C = 5'd2,
        OP_LSL_R  = 5'd3,
        OP_LSL_I  = 5'd4,
        OP_LSL_1C = 5'd5,
        OP_LSR_R  = 5'd6,
        OP_LSR_I  = 5'd7,
        OP_LSR_1C = 5'd8,
        OP_ROL_I  = 5'd9,
        OP_BREV   = 5'd10,
        OP_XSR    = 5'd11,
        OP_SEXT_B = 5'd12,
        OP_SEXT_H = 5'd13,
        OP_ZEXT_B = 5'd14,
        OP_ZEXT_H = 5'd15,
        OP_XTR_0  = 5'd16,
        OP_XTR_1  = 5'd17,
        OP_XTR_2  = 5'd18,
        OP_XTR_3  = 5'd19
    } edit_op_e;

endpackage

// File: rtl/bitedit_reverse.sv
// Bit-order reversal: output bit i is input bit W-1-i.
// Pure wiring; assumes nothing about W beyond W >= 1.
module bitedit_reverse #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    // Cross-wire each bit to its mirror position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[W-1-i];
    end

endmodule

// File: rtl/bitedit_rshift.sv
// Logarithmic right shifter with selectable fill: the vacated top bits
// take either a fill bit (zero, sign or carry) or, with wrap_en, the bits
// shifted out at the bottom (rotate right). Amounts are 0..W-1; the
// caller handles larger amounts. Assumes W is a power of two.
module bitedit_rshift #(
    parameter  int W  = 32,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  logic          wrap_en,
    input  logic          fill_bit,
    output logic [W-1:0]  dout
);

    logic [AW:0][W-1:0] stg;

    assign stg[0] = din;

    // One stage per amount bit; stage s moves data by 2**s positions.
    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int D = 1 << s;
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i + D < W) begin : g_inner
                assign stg[s+1][i] = amt[s] ? stg[s][i+D] : stg[s][i];
            end else begin : g_edge
                assign stg[s+1][i] = amt[s] ? (wrap_en ? stg[s][i+D-W] : fill_bit)
                                            : stg[s][i];
            end
        end
    end

    assign dout = stg[AW];

endmodule

// File: rtl/bitedit_extend.sv
// Byte/halfword extension and byte-lane extraction. With half_sel the low
// halfword is extended; otherwise the byte lane chosen by lane is.
// sign_sel selects sign extension, else zero extension.
// Assumes W is a multiple of 2*BW.
module bitedit_extend #(
    parameter  int W  = 32,
    parameter  int BW = 8,
    localparam int NL = W / BW,
    localparam int LW = $clog2(NL),
    localparam int HW = 2 * BW
) (
    input  logic [W-1:0]  din,
    input  logic          half_sel,
    input  logic          sign_sel,
    input  logic [LW-1:0] lane,
    output logic [W-1:0]  dout
);

    logic [NL-1:0][BW-1:0] lane_v;
    logic [BW-1:0]         picked;

    // Split the operand into its byte lanes.
    for (genvar l = 0; l < NL; l++) begin : g_lane
        assign lane_v[l] = din[l*BW +: BW];
    end

    // Pick the field and extend it to the full width.
    always_comb begin
        picked = lane_v[lane];
        if (half_sel) begin
            dout = {{(W-HW){sign_sel & din[HW-1]}}, din[HW-1:0]};
        end else begin
            dout = {{(W-BW){sign_sel & picked[BW-1]}}, picked};
        end
    end

endmodule

// File: rtl/bitedit_unit.sv
// Shift, extend and byte-extract unit (combinational). Decodes op_sel,
// routes the operand through a shared right shifter (left shifts and
// rotates use reversal on both sides of it), a reverser, or the extend
// block, and produces the carry update and register-1 destination flag.
// Assumes DATA_W = 32 so that the four extract codes cover all lanes.
module bitedit_unit
    import bitedit_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int SH_W   = $clog2(DATA_W),
    localparam int LANE_W = $clog2(DATA_W / 8)
) (
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] opnd,
    input  logic [SH_W:0]     shamt,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              carry_we,
    output logic              dest_r1
);

    edit_op_e            op;
    logic                is_shift;
    logic                is_left;
    logic                is_reg;
    logic                is_ext;
    logic                wrap_en;
    logic                fill_bit;
    logic                ext_half;
    logic                ext_sign;
    logic [SH_W-1:0]     amt;
    logic [LANE_W-1:0]   lane;
    logic                sat;
    logic [DATA_W-1:0]   rev_in;
    logic [DATA_W-1:0]   sh_in;
    logic [DATA_W-1:0]   sh_out;
    logic [DATA_W-1:0]   rev_out;
    logic [DATA_W-1:0]   ext_out;
    logic [DATA_W-1:0]   shift_res;

    assign op = edit_op_e'(op_sel);

    // Decode the operation into datapath controls.
    always_comb begin
        is_shift = 1'b0;
        is_left  = 1'b0;
        is_reg   = 1'b0;
        is_ext   = 1'b0;
        wrap_en  = 1'b0;
        fill_bit = 1'b0;
        ext_half = 1'b0;
        ext_sign = 1'b0;
        amt      = shamt[SH_W-1:0];
        lane     = '0;
        carry_we = 1'b0;
        dest_r1  = 1'b0;
        unique case (op)
            OP_ASR_R:  begin is_shift = 1'b1; is_reg = 1'b1; fill_bit = opnd[DATA_W-1]; end
            OP_ASR_I:  begin is_shift = 1'b1; fill_bit = opnd[DATA_W-1]; end
            OP_ASR_1C: begin is_shift = 1'b1; fill_bit = opnd[DATA_W-1];
                             amt = SH_W'(1); carry_we = 1'b1; end
            OP_LSL_R:  begin is_shift = 1'b1; is_left = 1'b1; is_reg = 1'b1; end
            OP_LSL_I:  begin is_shift = 1'b1; is_left = 1'b1; end
            OP_LSL_1C: begin is_shift = 1'b1; is_left = 1'b1;
                             amt = SH_W'(1); carry_we = 1'b1; end
            OP_LSR_R:  begin is_shift = 1'b1; is_reg = 1'b1; end
            OP_LSR_I:  begin is_shift = 1'b1; end
            OP_LSR_1C: begin is_shift = 1'b1; amt = SH_W'(1); carry_we = 1'b1; end
            OP_ROL_I:  begin is_shift = 1'b1; is_left = 1'b1; wrap_en = 1'b1; end
            OP_XSR:    begin is_shift = 1'b1; fill_bit = carry_in;
                             amt = SH_W'(1); carry_we = 1'b1; end
            OP_SEXT_B: begin is_ext = 1'b1; ext_sign = 1'b1; end
            OP_SEXT_H: begin is_ext = 1'b1; ext_sign = 1'b1; ext_half = 1'b1; end
            OP_ZEXT_B: begin is_ext = 1'b1; end
            OP_ZEXT_H: begin is_ext = 1'b1; ext_half = 1'b1; end
            OP_XTR_0, OP_XTR_1, OP_XTR_2, OP_XTR_3: begin
                is_ext  = 1'b1;
                lane    = op_sel[LANE_W-1:0];
                dest_r1 = 1'b1;
            end
            default: ;
        endcase
    end

    // Register-amount shifts of a full word or more saturate to the fill.
    assign sat = is_reg & shamt[SH_W];

    bitedit_reverse #(.W(DATA_W)) i_rev_in (
        .din  (opnd),
        .dout (rev_in)
    );

    assign sh_in = is_left ? rev_in : opnd;

    bitedit_rshift #(.W(DATA_W)) i_rshift (
        .din      (sh_in),
        .amt      (amt),
        .wrap_en  (wrap_en),
        .fill_bit (fill_bit),
        .dout     (sh_out)
    );

    bitedit_reverse #(.W(DATA_W)) i_rev_out (
        .din  (sh_out),
        .dout (rev_out)
    );

    bitedit_extend #(.W(DATA_W), .BW(8)) i_extend (
        .din      (opnd),
        .half_sel (ext_half),
        .sign_sel (ext_sign),
        .lane     (lane),
        .dout     (ext_out)
    );

    // Undo the input reversal for left-going operations, then saturate.
    always_comb begin
        if (sat) begin
            shift_res = {DATA_W{fill_bit}};
        end else if (is_left) begin
            shift_res = rev_out;
        end else begin
            shift_res = sh_out;
        end
    end

    // Select the final result from the three datapaths.
    always_comb begin
        if (is_shift) begin
            result = shift_res;
        end else if (op == OP_BREV) begin
            result = rev_in;
        end else if (is_ext) begin
            result = ext_out;
        end else begin
            result = '0;
        end
    end

    // New carry: the bit that left the word, or the old flag when not written.
    always_comb begin
        if (!carry_we) begin
            carry_out = carry_in;
        end else if (op == OP_LSL_1C) begin
            carry_out = opnd[DATA_W-1];
        end else begin
            carry_out = opnd[0];
        end
    end

endmodule

// File: rtl/bitedit_unit_chk.sv
// Property checker for bitedit_unit. The unit has no state, so the checks
// are immediate assertions evaluated whenever the ports change.
module bitedit_unit_chk #(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5
) (
    input logic [4:0]        op_sel,
    input logic [DATA_W-1:0] opnd,
    input logic [SH_W:0]     shamt,
    input logic              carry_in,
    input logic [DATA_W-1:0] result,
    input logic              carry_out,
    input logic              carry_we,
    input logic              dest_r1
);

    // Relate outputs to inputs for every operation code.
    always_comb begin
        // R11
        carry_hold_chk: assert (carry_we || (carry_out == carry_in));
        // R11
        carry_we_chk: assert (carry_we == (op_sel == 5'd2 || op_sel == 5'd5 ||
                                           op_sel == 5'd8 || op_sel == 5'd11));
        // R12
        dest_r1_chk: assert (dest_r1 == (op_sel >= 5'd16 && op_sel <= 5'd19));
        if (op_sel == 5'd11) begin
            // R7
            xsr_edge_chk: assert (result[DATA_W-1] == carry_in && carry_out == opnd[0]);
        end
        if (op_sel >= 5'd16 && op_sel <= 5'd19) begin
            // R10
            extract_hi_chk: assert (result[DATA_W-1:8] == '0);
        end
        if (op_sel == 5'd12) begin
            // R8
            sext_b_chk: assert (result[DATA_W-1:8] == {(DATA_W-8){opnd[7]}} &&
                                result[7:0] == opnd[7:0]);
        end
        if ((op_sel == 5'd3 || op_sel == 5'd6) && shamt[SH_W]) begin
            // R3
            sat_zero_chk: assert (result == '0);
        end
        if (op_sel >= 5'd20) begin
            // R1
            undef_zero_chk: assert (result == '0 && !carry_we && !dest_r1);
        end
        if (op_sel == 5'd10) begin
            for (int i = 0; i < DATA_W; i++) begin
                // R6
                brev_bit_chk: assert (result[i] == opnd[DATA_W-1-i]);
            end
        end
    end

endmodule

bind bitedit_unit bitedit_unit_chk #(.DATA_W(DATA_W), .SH_W(SH_W)) i_bitedit_unit_chk (
    .op_sel    (op_sel),
    .opnd      (opnd),
    .shamt     (shamt),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out),
    .carry_we  (carry_we),
    .dest_r1   (dest_r1)
);

// File: tb/test_bitedit_unit.sv
// Sweep bench for bitedit_unit: every operation code against a set of
// operand patterns, both carry values and (for amount-sensitive codes)
// every amount 0..63. Expected values use the language's own operators.
module test_bitedit_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] opnd = '0;
    logic [5:0]  shamt = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_out;
    logic        carry_we;
    logic        dest_r1;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bitedit_unit i_bitedit_unit (
        .op_sel    (op_sel),
        .opnd      (opnd),
        .shamt     (shamt),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out),
        .carry_we  (carry_we),
        .dest_r1   (dest_r1)
    );

    function automatic string tag_of(int op);
        case (op)
            0, 1:          return "R2";
            3, 4, 6, 7:    return "R3";
            2, 5, 8:       return "R4";
            9:             return "R5";
            10:            return "R6";
            11:            return "R7";
            12, 13:        return "R8";
            14, 15:        return "R9";
            16, 17, 18, 19: return "R10";
            default:       return "R1";
        endcase
    endfunction

    // Returns {dest_r1, carry_we, carry_out, result}.
    function automatic logic [34:0] model(int op, logic [31:0] a, logic [5:0] s, logic c);
        logic [31:0] r;
        logic        co;
        logic        we;
        logic        r1;
        int          k;
        r = '0; co = c; we = 1'b0; r1 = 1'b0;
        case (op)
            0:  r = (s >= 32) ? {32{a[31]}} : 32'($signed(a) >>> s);
            1:  r = 32'($signed(a) >>> s[4:0]);
            2:  begin r = 32'($signed(a) >>> 1); co = a[0]; we = 1'b1; end
            3:  r = (s >= 32) ? 32'd0 : a << s;
            4:  r = a << s[4:0];
            5:  begin r = a << 1; co = a[31]; we = 1'b1; end
            6:  r = (s >= 32) ? 32'd0 : a >> s;
            7:  r = a >> s[4:0];
            8:  begin r = a >> 1; co = a[0]; we = 1'b1; end
            9:  begin
                    k = int'(s[4:0]);
                    r = (k == 0) ? a : ((a << k) | (a >> (32 - k)));
                end
            10: for (int i = 0; i < 32; i++) r[i] = a[31-i];
            11: begin r = (a >> 1) + (c ? 32'h8000_0000 : 32'd0); co = a[0]; we = 1'b1; end
            12: r = 32'($signed(a[7:0]));
            13: r = 32'($signed(a[15:0]));
            14: r = a % 32'd256;
            15: r = a % 32'd65536;
            16, 17, 18, 19: begin r = (a >> (8 * (op - 16))) & 32'hFF; r1 = 1'b1; end
            default: r = '0;
        endcase
        return {r1, we, co, r};
    endfunction

    task automatic apply_check(int op, logic [31:0] a, logic [5:0] s, logic c);
        logic [34:0] exp;
        @(negedge clk);
        op_sel   = 5'(op);
        opnd     = a;
        shamt    = s;
        carry_in = c;
        #2;
        exp = model(op, a, s, c);
        checks++;
        if (result !== exp[31:0]) begin
            fails++;
            $display("FAIL %s op=%0d a=%h s=%0d c=%b: result %h expected %h",
                     tag_of(op), op, a, s, c, result, exp[31:0]);
        end
        checks++;
        if ({dest_r1, carry_we, carry_out} !== exp[34:32]) begin
            fails++;
            $display("FAIL R11 R12 (%s) op=%0d a=%h c=%b: r1/we/cout %b expected %b",
                     tag_of(op), op, a, c, {dest_r1, carry_we, carry_out}, exp[34:32]);
        end
    endtask

    // Watchdog: an overrun counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 190000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, cycles %0d expected < 190000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [0:29];
        logic [31:0] x;
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_0000; pats[3] = 32'h0000_0001;
        pats[4] = 32'h7FFF_FFFF; pats[5] = 32'hA5A5_A5A5;
        x = 32'h1234_5679;
        for (int i = 6; i < 30; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            pats[i] = x;
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state after reset: code 0 on zero operand gives zero, no flags (R1, R11).
        apply_check(0, 32'h0, 6'd0, 1'b0);
        // Undefined code gives zero result and keeps the carry (R1).
        apply_check(31, 32'hDEAD_BEEF, 6'd7, 1'b1);

        for (int op = 0; op < 32; op++) begin
            for (int v = 0; v < 30; v++) begin
                for (int c = 0; c < 2; c++) begin
                    if (op == 0 || op == 1 || op == 3 || op == 4 ||
                        op == 6 || op == 7 || op == 9) begin
                        for (int s = 0; s < 64; s++)
                            apply_check(op, pats[v], 6'(s), c[0]);
                    end else begin
                        apply_check(op, pats[v], 6'd0, c[0]);
                        apply_check(op, pats[v], 6'd1, c[0]);
                        apply_check(op, pats[v], 6'd31, c[0]);
                        apply_check(op, pats[v], 6'd63, c[0]);
                    end
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule